// File: doc/BRIEF.md
# Pin Event Interrupt Unit

This block collects thirty-two asynchronous pin lines and turns them into one interrupt request. Each line is brought into the clock domain, then watched for the event that its own trigger code selects: a rising edge, a falling edge, either edge, a high level or a low level. A detected event latches a pending bit, and the request output goes high whenever any pending bit is also enabled.

Software programs and services the unit over a plain 32-bit register bus with address, write data, write strobe, read strobe and registered read data. The trigger codes sit in four configuration words with eight 4-bit fields each. A single enable word masks lines from the request, and a single pending word is read to find the source and written with ones to acknowledge it.

Top module: `pin_irq_unit`

## Requirements
- R1: Line n's 4-bit trigger code lives in the word at offset 0x200 + 4*(n/8), bits (n mod 8)*4 upward; the four words (0x200, 0x204, 0x208, 0x20C) read back what was written.
- R2: Code 0 (rising) sets pending bit n when the synchronized line goes from 0 to 1, and not on a fall or a steady level.
- R3: Code 1 (falling) sets pending bit n when the synchronized line goes from 1 to 0, and not otherwise.
- R4: Code 2 sets pending bit n while the line is high and code 3 while it is low; after an acknowledge the bit sets again one clock later if the level is still present.
- R5: Code 4 sets pending bit n on both a rise and a fall of the line.
- R6: Codes 5 to 15 never set a pending bit.
- R7: The enable word at 0x210 holds line n at bit n and reads back; the pending word at 0x214 holds line n at bit n and sets on an event whether or not the line is enabled.
- R8: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged; an edge event in the same clock as the acknowledge keeps the bit set, while a level event yields to the acknowledge for that clock.
- R9: The request output equals the OR over all lines of (pending AND enable) as it stood one clock earlier.
- R10: Reset clears all trigger codes, enables and pending bits and drops the request; read data appears the clock after the read strobe and is zero for any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the clock after bus_rd |
| pin_in | input | 32 | Asynchronous pin lines, one per interrupt source |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The two functions that can meet in one clock are a software acknowledge of a pending bit and a fresh hardware event on that same line. The bench raises a line so that its edge is detected in exactly the clock in which the acknowledge write is sampled, counting the two synchronizer stages, and then reads the pending word expecting the bit still set. The level case of the same collision is judged by the bit reappearing after the acknowledge while the level is held.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;

  localparam logic [11:0] CODE_BASE = 12'h200;
  localparam logic [11:0] ENA_OFS   = 12'h210;
  localparam logic [11:0] PEND_OFS  = 12'h214;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              line_s,
  input  logic [CODE_W-1:0] code,
  output logic              edge_evt,
  output logic              level_evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= line_s;
  end

  always_comb begin
    edge_evt  = 1'b0;
    level_evt = 1'b0;
    case (code)
      TRIG_RISE: edge_evt  = line_s & ~prev_q;
      TRIG_FALL: edge_evt  = ~line_s & prev_q;
      TRIG_BOTH: edge_evt  = line_s ^ prev_q;
      TRIG_HIGH: level_evt = line_s;
      TRIG_LOW:  level_evt = ~line_s;
      default: begin
        edge_evt  = 1'b0;
        level_evt = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_LINES-1:0]        edge_evt,
  input  logic [NUM_LINES-1:0]        level_evt,
  output logic [NUM_LINES*CODE_W-1:0] code_vec,
  output logic [NUM_LINES-1:0]        ena_vec,
  output logic [NUM_LINES-1:0]        pend_vec
);
  localparam int PER_WORD = DATA_W / CODE_W;
  localparam int WORDS    = (NUM_LINES + PER_WORD - 1) / PER_WORD;
  localparam int CODE_BITS = WORDS * DATA_W;

  logic [CODE_BITS-1:0] code_q;
  logic [NUM_LINES-1:0] ena_q, pend_q, ack;
  logic [ADDR_W-1:0]    code_ofs;
  logic                 code_range, ena_hit, pend_hit;
  logic [DATA_W-1:0]    rd_mux;

  assign code_ofs   = bus_addr - ADDR_W'(CODE_BASE);
  assign code_range = (bus_addr >= ADDR_W'(CODE_BASE)) &&
                      (code_ofs < ADDR_W'(4 * WORDS)) && (bus_addr[1:0] == 2'b00);
  assign ena_hit    = (bus_addr == ADDR_W'(ENA_OFS));
  assign pend_hit   = (bus_addr == ADDR_W'(PEND_OFS));
  assign ack        = (bus_wr && pend_hit) ? bus_wdata[NUM_LINES-1:0] : '0;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) code_q[w*DATA_W +: DATA_W] <= '0;
      else if (bus_wr && code_range && (code_ofs[ADDR_W-1:2] == (ADDR_W-2)'(w)))
        code_q[w*DATA_W +: DATA_W] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q  <= '0;
      pend_q <= '0;
    end else begin
      if (bus_wr && ena_hit) ena_q <= bus_wdata[NUM_LINES-1:0];
      pend_q <= (pend_q & ~ack) | edge_evt | (level_evt & ~ack);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ena_hit)       rd_mux = DATA_W'(ena_q);
    else if (pend_hit) rd_mux = DATA_W'(pend_q);
    else if (code_range) begin
      for (int w = 0; w < WORDS; w++)
        if (code_ofs[ADDR_W-1:2] == (ADDR_W-2)'(w)) rd_mux = code_q[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_mux : '0;
  end

  assign code_vec = code_q[NUM_LINES*CODE_W-1:0];
  assign ena_vec  = ena_q;
  assign pend_vec = pend_q;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && pend_hit) |=> ((pend_q & $past(bus_wdata[NUM_LINES-1:0] & ~edge_evt)) == '0)); // R8
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && pend_hit) |=> (($past(pend_q) & ~pend_q) == '0)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !ena_hit && !pend_hit && !code_range) |=> (bus_rdata == '0)); // R10

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    AST_BAD_CODE_SILENT: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q[i]) |-> ($past(code_q[i*CODE_W +: CODE_W]) <= 4'd4)); // R6
  end
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0]        line_s, edge_evt, level_evt, ena_vec, pend_vec;
  logic [NUM_LINES*CODE_W-1:0] code_vec;

  pin_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(line_s)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    pin_irq_detect u_det (
      .clk(clk), .rst(rst), .line_s(line_s[i]),
      .code(code_vec[i*CODE_W +: CODE_W]),
      .edge_evt(edge_evt[i]), .level_evt(level_evt[i])
    );
  end

  pin_irq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .edge_evt(edge_evt), .level_evt(level_evt),
    .code_vec(code_vec), .ena_vec(ena_vec), .pend_vec(pend_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(pend_vec & ena_vec);
  end

  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_out == |$past(pend_vec & ena_vec))); // R9
endmodule

// File: tb/pin_irq_unit_tb.sv
`timescale 1ns/1ps
module pin_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pin_irq_unit u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // expected pending bit of the swept line after each phase of its stimulus
  function automatic bit expect_pend(int code, int phase);
    case (phase)
      1: return code == 3;
      2: return (code == 0) || (code == 2) || (code == 3) || (code == 4);
      3: return code == 2;
      default: return (code >= 1) && (code <= 4);
    endcase
  endfunction

  initial begin
    logic [31:0] d;
    int codes [7] = '{0, 1, 2, 3, 4, 5, 15};
    idle(4);
    rst = 1'b0;
    // R10 reset state
    check("R10 reset irq", {31'd0, irq_out}, 32'd0);
    rd(12'h210, d); check("R10 reset enable", d, 32'd0);
    rd(12'h214, d); check("R10 reset pending", d, 32'd0);
    for (int w = 0; w < 4; w++) begin
      rd(12'h200 + 12'(4*w), d); check("R10 reset code word", d, 32'd0);
    end

    // sweep every line through every trigger code (R1..R7)
    for (int n = 0; n < 32; n++) begin
      for (int k = 0; k < 7; k++) begin
        int c = codes[k];
        logic [11:0] wa = 12'h200 + 12'(4*(n/8));
        logic [31:0] wv = 32'(c) << ((n % 8) * 4);
        string tg;
        case (c)
          0: tg = "R2";  1: tg = "R3";  2, 3: tg = "R4";  4: tg = "R5"; default: tg = "R6";
        endcase
        wr(wa, wv);
        rd(wa, d); check("R1 code readback", d, wv);
        idle(5);
        wr(12'h214, 32'hFFFF_FFFF);
        idle(4);
        rd(12'h214, d); check({tg, " phase low"}, d, 32'(expect_pend(c, 1)) << n);
        pin_in[n] = 1'b1;
        idle(6);
        rd(12'h214, d); check({tg, " phase rise"}, d, 32'(expect_pend(c, 2)) << n);
        wr(12'h214, 32'hFFFF_FFFF);
        idle(4);
        rd(12'h214, d); check({tg, " phase high after ack"}, d, 32'(expect_pend(c, 3)) << n);
        pin_in[n] = 1'b0;
        idle(6);
        rd(12'h214, d); check({tg, " phase fall"}, d, 32'(expect_pend(c, 4)) << n);
        wr(wa, 32'd0);
        wr(12'h214, 32'hFFFF_FFFF);
      end
    end
    check("R7 no irq while all lines disabled", {31'd0, irq_out}, 32'd0);

    // enable gating and combined request (R7, R9)
    idle(3);
    wr(12'h210, 32'h0000_0080);
    rd(12'h210, d); check("R7 enable readback", d, 32'h0000_0080);
    pin_in[7] = 1'b1;
    idle(8);
    check("R9 irq on enabled pending", {31'd0, irq_out}, 32'd1);
    wr(12'h210, 32'h0000_0000);
    idle(1);
    check("R9 irq drops when disabled", {31'd0, irq_out}, 32'd0);
    rd(12'h214, d); check("R7 pending kept while disabled", d, 32'h0000_0080);
    wr(12'h214, 32'h0000_0000);
    rd(12'h214, d); check("R8 writing zero keeps pending", d, 32'h0000_0080);
    wr(12'h210, 32'h0000_0080);
    idle(1);
    check("R9 irq back when re-enabled", {31'd0, irq_out}, 32'd1);
    wr(12'h214, 32'h0000_0080);
    idle(2);
    check("R9 irq drops after ack", {31'd0, irq_out}, 32'd0);
    rd(12'h214, d); check("R8 ack clears", d, 32'd0);
    pin_in[7] = 1'b0;
    wr(12'h210, 32'd0);

    // ack in the same clock as a new rising edge on line 9 (R8)
    pin_in[9] = 1'b1; idle(6); pin_in[9] = 1'b0; idle(6);
    rd(12'h214, d); check("R8 line9 pending before collision", d, 32'h0000_0200);
    @(negedge clk); pin_in[9] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = 12'h214; bus_wdata = 32'h0000_0200; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(12'h214, d); check("R8 edge wins over ack", d, 32'h0000_0200);
    wr(12'h214, 32'h0000_0200);
    rd(12'h214, d); check("R8 ack after collision", d, 32'd0);
    pin_in[9] = 1'b0;

    // unmapped offsets (R10)
    wr(12'h100, 32'hDEAD_BEEF);
    rd(12'h100, d); check("R10 unmapped read 0x100", d, 32'd0);
    rd(12'h218, d); check("R10 unmapped read 0x218", d, 32'd0);
    rd(12'h202, d); check("R10 misaligned read", d, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule